// File: doc/BRIEF.md
# Nanosecond Real-Time Counter with Alarm Interrupt

This block keeps a free-running 64-bit time count in nanoseconds and offers one programmable alarm that drives a level interrupt. The count grows by a fixed step, `NS_PER_CLK`, on every clock. Software can overwrite either 32-bit half of the count and leave the other half alone. It reaches the block through a plain 32-bit register port: one access per cycle, marked by a valid strobe and a write flag, at byte addresses that must be word aligned.

Reading the lower half of the count also captures the upper half in a holding register. A following read of the upper half returns that captured value, so software always sees a consistent 64-bit time even when a carry crosses into the upper half between the two reads. The alarm target is also written in halves. Only the write of the lower target half arms the alarm. If the target has already been reached when the alarm is armed, the interrupt becomes pending at once. Otherwise the alarm runs until the count is greater than or equal to the target. The `>=` test means a step larger than one cannot jump over the target. The interrupt pin is the pending flag gated by an enable bit.

Read data comes back on a response channel one cycle after the read request. The channel has valid but no ready: the requester must always accept a response, so there is no back-pressure.

Top module: `rtc_ns_alarm`

## Requirements
- R1: After reset the count, the alarm target, the captured upper half and the running, pending and enable flags are all zero, so `irq` is 0.
- R2: In every cycle without a count write, the count increases by `NS_PER_CLK`, wrapping modulo 2^64.
- R3: A read at byte address 0x00 returns count bits 31:0 and captures count bits 63:32 in that same access. A read at 0x04 returns the captured value, not the live upper half.
- R4: A write at 0x00 replaces count bits 31:0 and keeps bits 63:32. A write at 0x04 replaces bits 63:32 and keeps bits 31:0. In both cases the step is not added in that cycle.
- R5: A write at 0x0C stores target bits 63:32 and does not arm the alarm. A write at 0x08 stores target bits 31:0 and then arms the alarm against the full target.
- R6: If the full target is less than or equal to the count at the moment of arming, pending is set in the same cycle and the alarm is left not running.
- R7: If the target is greater than the count at arming, the running flag is set. In the first cycle in which a running alarm sees count >= target, running clears and pending sets.
- R8: `irq` equals pending AND enable. A write at 0x10 keeps only bit 0 of the data as the enable bit, and `irq` follows from the next cycle.
- R9: A write of any data at 0x1C clears pending. A write at 0x14 stops a running alarm and leaves pending unchanged.
- R10: Reads return the target halves at 0x08 and 0x0C, the enable bit at 0x10 (bit 0) and the running flag at 0x18 (bit 0).
- R11: Reads of write-only (0x14, 0x1C), unmapped (0x20 and up) or misaligned addresses return zero. Writes to unmapped or misaligned addresses change no state.
- R12: `rsp_valid` is high for exactly one cycle, the cycle after each read request, and `rsp_rdata` carries the data in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after the read |
| rsp_rdata | output | DATA_W | Read response data |
| irq | output | 1 | Level interrupt: pending AND enable |

## Verification
The assertions assume at most one access per cycle. Under that assumption, arming, cancelling and clearing never fall in the same cycle, and the properties on cancel and pending rely on this. The properties also assume that reset is held low from time zero across at least one clock edge. The bench makes every access through a task that holds `bus_valid` for exactly one cycle and then leaves an idle cycle, so these assumptions always hold. It asserts reset before the first edge and sets alarm targets far from a lower-half carry, so the cycle in which an alarm fires can be worked out by hand.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Byte offsets of the register window; software depends on these positions.
  localparam int unsigned OFS_TIME_LO  = 32'h00;
  localparam int unsigned OFS_TIME_HI  = 32'h04;
  localparam int unsigned OFS_ALM_LO   = 32'h08;
  localparam int unsigned OFS_ALM_HI   = 32'h0C;
  localparam int unsigned OFS_IRQ_EN   = 32'h10;
  localparam int unsigned OFS_ALM_STOP = 32'h14;
  localparam int unsigned OFS_STATUS   = 32'h18;
  localparam int unsigned OFS_IRQ_ACK  = 32'h1C;
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned STEP   = 10,
  localparam int unsigned CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              snap,
  input  logic [HALF_W-1:0] wdata,
  output logic [CNT_W-1:0]  count,
  output logic [HALF_W-1:0] held_hi
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      held_hi <= '0;
    end else begin
      if (wr_lo)      count <= {count[CNT_W-1:HALF_W], wdata};
      else if (wr_hi) count <= {wdata, count[HALF_W-1:0]};
      else            count <= count + CNT_W'(STEP);
      if (snap) held_hi <= count[CNT_W-1:HALF_W];
    end
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(wr_lo || wr_hi) |-> count == $past(count) + CNT_W'(STEP));
  p_low_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(wr_lo) |-> count[HALF_W-1:0] == $past(wdata)
      && count[CNT_W-1:HALF_W] == $past(count[CNT_W-1:HALF_W]));
  p_snapshot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(snap) |-> held_hi == $past(count[CNT_W-1:HALF_W]));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int unsigned HALF_W = 32,
  localparam int unsigned CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic              wr_tgt_lo,
  input  logic              wr_tgt_hi,
  input  logic              wr_en,
  input  logic              stop,
  input  logic              ack,
  input  logic [HALF_W-1:0] wdata,
  output logic [CNT_W-1:0]  target,
  output logic              running,
  output logic              pending,
  output logic              enable,
  output logic              irq
);
  logic [CNT_W-1:0] armed_target;
  logic             already_due;
  logic             reached;

  always_comb begin
    armed_target = {target[CNT_W-1:HALF_W], wdata};
    already_due  = armed_target <= count;
    reached      = running && (count >= target);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target  <= '0;
      running <= 1'b0;
      pending <= 1'b0;
      enable  <= 1'b0;
    end else begin
      if (wr_tgt_hi) target[CNT_W-1:HALF_W] <= wdata;
      if (wr_tgt_lo) target[HALF_W-1:0]     <= wdata;

      if (wr_tgt_lo)              running <= !already_due;
      else if (stop || reached)   running <= 1'b0;

      if ((wr_tgt_lo && already_due) || (reached && !stop && !wr_tgt_lo))
        pending <= 1'b1;
      else if (ack)
        pending <= 1'b0;

      if (wr_en) enable <= wdata[0];
    end
  end

  assign irq = pending & enable;

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  p_due_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(wr_tgt_lo) && target <= $past(count) |-> pending && !running);
  p_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $fell(running) && !$past(stop) && !$past(wr_tgt_lo) |-> pending);
  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(stop) |-> !running && pending == $past(pending));
  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(ack) && !$past(reached) |-> !pending);
endmodule

// File: rtl/rtc_ns_alarm.sv
module rtc_ns_alarm
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NS_PER_CLK = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic rd, wr;
  logic at_time_lo, at_time_hi, at_alm_lo, at_alm_hi;
  logic at_en, at_stop, at_status, at_ack;

  always_comb begin
    rd         = bus_valid && !bus_write;
    wr         = bus_valid &&  bus_write;
    at_time_lo = bus_addr == ADDR_W'(OFS_TIME_LO);
    at_time_hi = bus_addr == ADDR_W'(OFS_TIME_HI);
    at_alm_lo  = bus_addr == ADDR_W'(OFS_ALM_LO);
    at_alm_hi  = bus_addr == ADDR_W'(OFS_ALM_HI);
    at_en      = bus_addr == ADDR_W'(OFS_IRQ_EN);
    at_stop    = bus_addr == ADDR_W'(OFS_ALM_STOP);
    at_status  = bus_addr == ADDR_W'(OFS_STATUS);
    at_ack     = bus_addr == ADDR_W'(OFS_IRQ_ACK);
  end

  logic [CNT_W-1:0]  count, target;
  logic [DATA_W-1:0] held_hi;
  logic              running, pending, enable;

  rtc_counter #(.HALF_W(DATA_W), .STEP(NS_PER_CLK)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (wr && at_time_lo),
    .wr_hi   (wr && at_time_hi),
    .snap    (rd && at_time_lo),
    .wdata   (bus_wdata),
    .count   (count),
    .held_hi (held_hi)
  );

  rtc_alarm #(.HALF_W(DATA_W)) u_alarm (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .wr_tgt_lo (wr && at_alm_lo),
    .wr_tgt_hi (wr && at_alm_hi),
    .wr_en     (wr && at_en),
    .stop      (wr && at_stop),
    .ack       (wr && at_ack),
    .wdata     (bus_wdata),
    .target    (target),
    .running   (running),
    .pending   (pending),
    .enable    (enable),
    .irq       (irq)
  );

  logic [DATA_W-1:0] rd_mux;
  logic              readable;

  always_comb begin
    readable = at_time_lo || at_time_hi || at_alm_lo || at_alm_hi || at_en || at_status;
    rd_mux   = '0;
    if (at_time_lo)     rd_mux = count[DATA_W-1:0];
    else if (at_time_hi) rd_mux = held_hi;
    else if (at_alm_lo)  rd_mux = target[DATA_W-1:0];
    else if (at_alm_hi)  rd_mux = target[CNT_W-1:DATA_W];
    else if (at_en)      rd_mux = DATA_W'(enable);
    else if (at_status)  rd_mux = DATA_W'(running);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(rd && !readable) |-> rsp_valid && rsp_rdata == '0);
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(wr && at_en && !bus_wdata[0]) |-> !irq);
endmodule

// File: tb/test_rtc_ns_alarm.sv
module test_rtc_ns_alarm;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned STEP = 10;

  logic        clk, rst_n;
  logic        bus_valid, bus_write;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq;

  rtc_ns_alarm #(.ADDR_W(6), .DATA_W(32), .NS_PER_CLK(STEP)) i_rtc_ns_alarm (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_run = 0;
  int n_fail = 0;

  // Reference count and captured upper half, built from R2, R3, R4.
  logic [63:0] m_cnt;
  logic [31:0] m_hold;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt  <= '0;
      m_hold <= '0;
    end else begin
      if (bus_valid && bus_write && bus_addr == 6'h00)      m_cnt <= {m_cnt[63:32], bus_wdata};
      else if (bus_valid && bus_write && bus_addr == 6'h04) m_cnt <= {bus_wdata, m_cnt[31:0]};
      else                                                  m_cnt <= m_cnt + 64'(STEP);
      if (bus_valid && !bus_write && bus_addr == 6'h00) m_hold <= m_cnt[63:32];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Scoreboard of expected read responses.
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 response without request", 64'(rsp_rdata), 64'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rsp_rdata == e, t, 64'(rsp_rdata), 64'(e));
      end
    end
  end

  task automatic do_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  // kind 0: constant expectation, 1: live low count, 2: captured upper half
  task automatic do_read(input logic [5:0] a, input int kind, input logic [31:0] e, input string tag);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R12 no response while idle", 64'(rsp_valid), 64'h0);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    if (kind == 1)      exp_q.push_back(m_cnt[31:0]);
    else if (kind == 2) exp_q.push_back(m_hold);
    else                exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
    check(rsp_valid == 1'b1, "R12 response one cycle after read", 64'(rsp_valid), 64'h1);
  endtask

  task automatic check_irq(input logic e, input string tag);
    check(irq == e, tag, 64'(irq), 64'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'h0, 64'h1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    check_irq(1'b0, "R1 irq low in reset");
    rst_n = 1'b1;

    // R1 reset values
    do_read(6'h18, 0, 32'h0, "R1 status zero after reset");
    do_read(6'h08, 0, 32'h0, "R1 target low zero after reset");
    do_read(6'h0C, 0, 32'h0, "R1 target high zero after reset");
    do_read(6'h10, 0, 32'h0, "R1 enable zero after reset");
    do_read(6'h04, 0, 32'h0, "R1 captured high zero after reset");

    // R2 free-running count sampled at two points
    do_read(6'h00, 1, 32'h0, "R2 count low first sample");
    repeat (7) @(negedge clk);
    do_read(6'h00, 1, 32'h0, "R2 count low after idle cycles");

    // R4 high write keeps low half; R3 captured high via low read
    do_write(6'h04, 32'h0000_00AB);
    do_read(6'h00, 1, 32'h0, "R4 low kept after high write");
    do_read(6'h04, 0, 32'h0000_00AB, "R4 high half replaced");

    // R3 carry between the two reads: held value stays coherent
    do_write(6'h04, 32'h0000_0001);
    do_write(6'h00, 32'hFFFF_FFF0);
    do_read(6'h00, 0, 32'hFFFF_FFFA, "R4 low replaced then stepped");
    do_read(6'h04, 0, 32'h0000_0001, "R3 high read returns held not live");
    do_read(6'h00, 1, 32'h0, "R3 low after carry");
    do_read(6'h04, 0, 32'h0000_0002, "R3 held high after carry");

    // R5/R6 target already passed: pending at once, not running
    do_write(6'h0C, 32'h0);
    do_read(6'h18, 0, 32'h0, "R5 high target write does not arm");
    do_write(6'h08, 32'h5);
    do_read(6'h18, 0, 32'h0, "R6 past target leaves alarm stopped");
    check_irq(1'b0, "R8 pending masked while disabled");
    do_write(6'h10, 32'hFFFF_FFFE);
    do_read(6'h10, 0, 32'h0, "R8 enable keeps only bit 0");
    check_irq(1'b0, "R8 irq low with bit 0 clear");
    do_write(6'h10, 32'h3);
    do_read(6'h10, 0, 32'h1, "R10 enable reads back");
    check_irq(1'b1, "R6 pending set on past target");
    do_read(6'h08, 0, 32'h5, "R10 target low reads back");
    do_read(6'h0C, 0, 32'h0, "R10 target high reads back");

    // R9 acknowledge
    do_write(6'h1C, 32'h0);
    check_irq(1'b0, "R9 pending cleared by ack");

    // R7 future target: fires in the first cycle count >= target
    do_write(6'h0C, m_cnt[63:32]);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 6'h08; bus_wdata = m_cnt[31:0] + 32'd25;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    check_irq(1'b0, "R7 not fired right after arm");
    @(negedge clk);
    check_irq(1'b0, "R7 not fired at count+10");
    @(negedge clk);
    check_irq(1'b0, "R7 not fired at count+20");
    @(negedge clk);
    check_irq(1'b1, "R7 fired when count passes target");
    do_read(6'h18, 0, 32'h0, "R7 running cleared on fire");

    // R9 stop a running alarm, pending unchanged
    do_write(6'h0C, m_cnt[63:32] + 32'd1);
    do_write(6'h08, 32'h0);
    do_read(6'h18, 0, 32'h1, "R7 running set for future target");
    do_write(6'h14, 32'h0);
    do_read(6'h18, 0, 32'h0, "R9 stop cancels running");
    check_irq(1'b1, "R9 stop leaves pending");
    do_write(6'h1C, 32'hFFFF_FFFF);
    repeat (20) @(negedge clk);
    check_irq(1'b0, "R9 stopped alarm never fires");

    // R11 write-only, unmapped and misaligned
    do_read(6'h14, 0, 32'h0, "R11 write-only stop reads zero");
    do_read(6'h1C, 0, 32'h0, "R11 write-only ack reads zero");
    do_read(6'h20, 0, 32'h0, "R11 unmapped reads zero");
    do_read(6'h3C, 0, 32'h0, "R11 top address reads zero");
    do_read(6'h12, 0, 32'h0, "R11 misaligned reads zero");
    do_write(6'h20, 32'hFFFF_FFFF);
    do_write(6'h11, 32'hFFFF_FFFF);
    do_write(6'h0A, 32'h1234_5678);
    do_read(6'h10, 0, 32'h1, "R11 enable untouched by stray writes");
    do_read(6'h08, 0, 32'h0, "R11 target low untouched by stray writes");
    do_read(6'h00, 1, 32'h0, "R11 count untouched by stray writes");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R12 all responses seen", 64'(exp_q.size()), 64'h0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule